// File: doc/BRIEF.md
# Multi-Rail Power-Good Supervisor Core

This block is the clocked decision logic behind a four-rail supply supervisor. Each rail has an analog comparator in front of it, and the block receives one result bit per rail, where 1 means the rail sits above its trip point. The block brings those bits into its clock domain through a two-flop stage. From them it drives three rail enables and one combined power-good flag.

The first three rails each own one enable output. That output turns on only after its rail has stayed good for a short qualification time, and it turns off as soon as the rail goes bad. The fourth rail has no enable of its own and feeds only the power-good decision. Power-good needs all four rails good for a long qualification time. It drops when any rail goes bad. Any dip, even one clock long, restarts the affected timers from zero.

Both delays are given in clock cycles. By default they are computed from the clock frequency as 30 µs and 190 ms. A simulation switch replaces them with short cycle counts.

Top module: `rail_supervisor`

## Requirements
- R1: While `rst_i` is high, all outputs are low by the clock edge after it is seen. Reset also clears every qualification timer, so after release each delay runs its full length again.
- R2: For k in 0..2, `en_o[k]` goes high two rising edges after the edge at which `mon_i[k]` has been sampled high on EN_CYC consecutive rising edges. It is never high earlier than that.
- R3: For k in 0..2, a low sample of `mon_i[k]` at a rising edge makes `en_o[k]` low two edges later.
- R4: `pg_o` goes high two rising edges after the edge at which all four bits of `mon_i` have been sampled high together on PG_CYC consecutive edges. It is never high earlier than that.
- R5: A low sample of any `mon_i` bit at a rising edge makes `pg_o` low two edges later.
- R6: When only `mon_i[3]` drops, `pg_o` falls and every `en_o` bit keeps its value.
- R7: A low sample lasting a single clock restarts the affected delays from zero. On recovery, the full EN_CYC or PG_CYC count is needed again.
- R8: Bit k of `mon_i` controls only `en_o[k]` for k = 0, 1, 2. Bit 3 feeds only `pg_o`. This mapping holds the same way before and after `pg_o` has first gone high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mon_i | input | NUM_RAILS (4) | Comparator results, one per rail, 1 = above threshold |
| en_o | output | NUM_RAILS-1 (3) | Delayed enables for rails 0 to 2 |
| pg_o | output | 1 | Combined power-good, delayed on rise |

## Verification
The bench builds the block with SIM_FAST=1, an enable delay of 4 cycles and a power-good delay of 20 cycles. At these values, full qualification, a one-cycle glitch followed by a complete restart, a dip on the fourth rail alone, and a reset in the middle of a run all fit within a few dozen cycles each. A reference model compares every output on every cycle against run-length counts of the raw inputs. This covers a long sweep of random input patterns held for random lengths, so both early assertion and late deassertion are caught.

// File: rtl/pg_pkg.sv
package pg_pkg;

    // Delay targets in microseconds
    localparam longint EN_DELAY_US = 30;
    localparam longint PG_DELAY_US = 190_000;

    // Round a time up to whole clock cycles, minimum one cycle
    function automatic int us_to_cycles(input longint clk_hz, input longint us);
        longint c;
        c = (clk_hz * us + 64'd999_999) / 64'd1_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/rail_qual_timer.sv
module rail_qual_timer #(
    parameter int DLY = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic in_i,
    output logic done_o
);

    localparam int            CW    = $clog2(DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DLY);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!in_i) begin
            // any low sample drops the output and restarts the count
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.done = ((st_q.cnt + 1'b1) == LIMIT);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign done_o = st_q.done;

    AST_DONE_NEEDS_FULL_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.done |-> (st_q.cnt == LIMIT)); // R2

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= LIMIT); // R4

    AST_LOW_RESTARTS: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_i |=> (st_q.cnt == '0) && !done_o); // R7

endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
    import pg_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int NUM_RAILS  = 4,
    parameter bit SIM_FAST   = 1'b0,
    parameter int SIM_EN_CYC = 4,
    parameter int SIM_PG_CYC = 20
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_RAILS-1:0] mon_i,
    output logic [NUM_RAILS-2:0] en_o,
    output logic                 pg_o
);

    localparam int NUM_EN = NUM_RAILS - 1;
    localparam int EN_CYC = SIM_FAST ? SIM_EN_CYC : us_to_cycles(CLK_HZ, EN_DELAY_US);
    localparam int PG_CYC = SIM_FAST ? SIM_PG_CYC : us_to_cycles(CLK_HZ, PG_DELAY_US);

    logic [NUM_RAILS-1:0] mon_s;
    logic                 all_good;

    rail_sync #(.W(NUM_RAILS)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (mon_i),
        .q_o   (mon_s)
    );

    assign all_good = &mon_s;

    generate
        for (genvar g = 0; g < NUM_EN; g++) begin : g_en
            rail_qual_timer #(.DLY(EN_CYC)) u_en (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .in_i   (mon_s[g]),
                .done_o (en_o[g])
            );

            AST_EN_FALLS: assert property (@(posedge clk_i) disable iff (rst_i)
                !mon_s[g] |=> !en_o[g]); // R3
        end
    endgenerate

    rail_qual_timer #(.DLY(PG_CYC)) u_pg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .in_i   (all_good),
        .done_o (pg_o)
    );

    AST_PG_FALLS: assert property (@(posedge clk_i) disable iff (rst_i)
        !all_good |=> !pg_o); // R5

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (en_o == '0) && !pg_o); // R1

    generate
        if (PG_CYC >= EN_CYC) begin : g_pg_order
            AST_PG_NEEDS_ENABLES: assert property (@(posedge clk_i) disable iff (rst_i)
                pg_o |-> (&en_o)); // R4
        end
    endgenerate

endmodule

// File: tb/tb_rail_supervisor.sv
`timescale 1ns/1ps
module tb_rail_supervisor;

    localparam int EN_C = 4;
    localparam int PG_C = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mon = 4'b0000;
    logic [2:0] en;
    logic       pg;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1 reset";

    logic [3:0] expq[$];
    int         streak[4];
    int         all_streak;

    always #2.5 clk = ~clk;

    rail_supervisor #(
        .CLK_HZ     (200_000_000),
        .NUM_RAILS  (4),
        .SIM_FAST   (1'b1),
        .SIM_EN_CYC (EN_C),
        .SIM_PG_CYC (PG_C)
    ) dut (
        .clk_i (clk),
        .rst_i (rst),
        .mon_i (mon),
        .en_o  (en),
        .pg_o  (pg)
    );

    // driver side: apply a value for the coming edge and push the expected result
    task automatic apply(input logic [3:0] v);
        logic [3:0] e;
        mon = v;
        for (int k = 0; k < 4; k++)
            streak[k] = v[k] ? ((streak[k] < 100000) ? streak[k] + 1 : streak[k]) : 0;
        all_streak = (&v) ? ((all_streak < 100000) ? all_streak + 1 : all_streak) : 0;
        for (int k = 0; k < 3; k++) e[k] = (streak[k] >= EN_C);
        e[3] = (all_streak >= PG_C);
        expq.push_back(e);
    endtask

    task automatic step(input logic [3:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            apply(v);
        end
    endtask

    task automatic check_quiet(input string t);
        checks++;
        if (en !== 3'b000 || pg !== 1'b0) begin
            fails++;
            $display("FAIL %s: got pg=%b en=%b exp pg=0 en=000", t, pg, en);
        end
    endtask

    task automatic do_reset(input logic [3:0] v);
        @(negedge clk);
        rst = 1'b1;
        mon = v;
        expq.delete();
        for (int k = 0; k < 4; k++) streak[k] = 0;
        all_streak = 0;
        repeat (3) @(negedge clk);
        check_quiet("R1 outputs low during reset");
        rst = 1'b0;
        apply(v);
    endtask

    // monitor side: compare each cycle against the item pushed two edges earlier
    always @(posedge clk) begin
        #1;
        if (!rst && expq.size() >= 3) begin
            logic [3:0] e;
            e = expq.pop_front();
            checks++;
            if ({pg, en} !== e) begin
                fails++;
                $display("FAIL %s: got pg=%b en=%b exp pg=%b en=%b",
                         tag, pg, en, e[3], e[2:0]);
            end
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) streak[k] = 0;
        all_streak = 0;
        repeat (3) @(negedge clk);
        check_quiet("R1 outputs low out of reset");
        rst = 1'b0;
        apply(4'b0000);

        tag = "R2 R8 rail0 alone";              step(4'b0001, 10);
        tag = "R2 R8 rail1 joins";              step(4'b0011, 8);
        tag = "R2 R8 rail2 joins";              step(4'b0111, 8);
        tag = "R4 all rails qualify";           step(4'b1111, 30);
        tag = "R6 rail3 dip keeps enables";     step(4'b0111, 3);
        tag = "R7 R4 power-good restarts";      step(4'b1111, 30);
        tag = "R3 R5 rail1 low";                step(4'b1101, 6);
        tag = "R2 R4 rail1 recovers";           step(4'b1111, 30);
        tag = "R7 one-cycle glitch rail0";      step(4'b1110, 1);
        tag = "R7 recovery after glitch";       step(4'b1111, 30);
        tag = "R6 one-cycle glitch rail3";      step(4'b0111, 1);
        tag = "R6 recovery rail3";              step(4'b1111, 30);
        tag = "R3 R5 all rails low";            step(4'b0000, 8);
        tag = "R1 run up before reset";         step(4'b1111, 30);
        do_reset(4'b1111);
        tag = "R1 full delay after reset";      step(4'b1111, 30);

        tag = "R8 random pattern sweep";
        for (int i = 0; i < 200; i++) begin
            logic [3:0] v;
            v = 4'($urandom_range(0, 15));
            if ((i % 5) == 0) v = 4'b1111;
            step(v, int'($urandom_range(1, 26)));
        end
        tag = "R3 R5 final drain";              step(4'b0000, 6);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule